// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the serial slave side of a byte-wide nonvolatile memory holding 2048 bytes. It watches the four host pins (serial clock, serial data in, active-low select and active-low pause) through synchronizers clocked by a faster system clock. It collects an 8-bit instruction, a 16-bit address and data bytes, and returns read data or status on a serial output. The output has a separate enable that stands in for a tristate driver.

The block does not hold the array, the write-enable latch or the status byte. It asks a memory port for read bytes, hands written bytes and commit/latch/status requests to a write engine as single-cycle pulses, and takes a busy flag and a status byte back. Both clock polarities that idle low (mode 0) and idle high (mode 3) work, because only the edges of the serial clock matter.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: While select is high, and from reset until a streaming instruction shifts its first bit, `so_oe` is 0. A new instruction is accepted only after a high-to-low select transition.
- R2: Serial input is captured on serial-clock rising edges, and `so` changes only after a falling edge. Transfers work the same whether the clock idles low (mode 0) or high (mode 3).
- R3: The write-enable-set instruction 0x06 gives one `wel_set` pulse, and the write-enable-clear instruction 0x04 gives one `wel_clr` pulse. Each pulse comes only after all 8 instruction bits are received and select then rises, never before.
- R4: The read instruction 0x03, followed by a 16-bit address sent MSB first, streams the byte at that address MSB first. The address then advances by one per byte for as long as clocks continue.
- R5: Only the low 11 address bits are used; the upper 5 are ignored. A read that passes 0x7FF continues at 0x000.
- R6: The status read instruction 0x05 streams `status_in` MSB first, repeating it every byte. It works even while `wr_busy` is 1.
- R7: The write instruction 0x02 with a 16-bit address emits one `wr_byte_valid` pulse per complete data byte, carrying `wr_addr` (starting at the given address and advancing by one) and `wr_data`. A trailing partial byte is dropped. `wr_commit` pulses once when select rises if at least one byte was taken.
- R8: The status write instruction 0x01 takes its first complete data byte. When select rises, it pulses `sr_wr_req` with that byte on `sr_wr_data`; later bytes are ignored.
- R9: A pause input that goes low while the serial clock is low freezes the transfer. While paused, clock and data edges are ignored and `so_oe` is 0. Releasing the pause while the clock is low resumes the transfer with no bit lost.
- R10: An opcode outside the six listed produces no output enable, no pulses and no data bytes until select falls again.
- R11: While `wr_busy` is 1 at the end of the opcode byte, every instruction except status read is ignored: no pulses, no data bytes, no output enable.
- R12: Raising select partway through an instruction discards it and resets the bit count, so the next selection starts a clean opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data input pin |
| cs_n | input | 1 | Active-low select pin |
| hold_n | input | 1 | Active-low pause pin |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for `so`; 0 models high impedance |
| wr_busy | input | 1 | Write engine busy with an internal write cycle |
| status_in | input | 8 | Status byte supplied by the status unit |
| rd_addr | output | 11 | Read address to the array |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_byte_valid | output | 1 | One-cycle pulse: a data byte for the write engine |
| wr_addr | output | 11 | Address of the byte being handed over |
| wr_data | output | 8 | Data byte being handed over |
| wr_commit | output | 1 | One-cycle pulse: start the internal write |
| wel_set | output | 1 | One-cycle pulse: set the write-enable latch |
| wel_clr | output | 1 | One-cycle pulse: clear the write-enable latch |
| sr_wr_req | output | 1 | One-cycle pulse: write the status byte |
| sr_wr_data | output | 8 | Status byte to write |

## Verification
A wrong bit count or phase shows up at the ports within one serial byte. Read data comes out shifted by a bit, a command pulse is missing or stray, or the output enable rises during a muted or paused transfer. Address errors show in the second streamed byte, and in the byte after 0x7FF, where the wrap must land on 0x000. A pause that leaks an edge shifts every later bit, so it shows in the same byte. Pulse timing is tied to the select rising edge, so a pulse that fires early can be seen before select is released.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int BYTE_W = 8;
  localparam int XADDR_W = 16;

  localparam logic [BYTE_W-1:0] OP_WEN_SET = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WEN_CLR = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] OP_STAT_WR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_MEM_RD  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_MEM_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_DIN, PH_STREAM_MEM, PH_STREAM_STAT, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {PEND_NONE, PEND_SET, PEND_CLR} latch_req_t;

  // true for the six decoded instructions
  function automatic logic op_known(input logic [BYTE_W-1:0] op);
    return (op == OP_WEN_SET) || (op == OP_WEN_CLR) || (op == OP_STAT_RD) ||
           (op == OP_STAT_WR) || (op == OP_MEM_RD) || (op == OP_MEM_WR);
  endfunction

  // next address inside an array described by its mask
  function automatic logic [XADDR_W-1:0] addr_next(input logic [XADDR_W-1:0] a,
                                                    input logic [XADDR_W-1:0] mask);
    return (a + 16'd1) & mask;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic si,
  input  logic cs_n,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic sel,
  output logic cs_fall_ev,
  output logic cs_rise_ev,
  output logic held
);
  localparam int NPIN = 4;
  // pin order {hold_n, cs_n, si, sck}
  localparam logic [NPIN-1:0] PIN_RST = 4'b1100;

  logic [SYNC_STAGES-1:0][NPIN-1:0] stg;
  logic [NPIN-1:0] pins_s, pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {SYNC_STAGES{PIN_RST}};
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= {hold_n, cs_n, si, sck};
    end
  end

  assign pins_s = stg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PIN_RST;
      held   <= 1'b0;
    end else begin
      pins_q <= pins_s;
      // pause state may only change while the serial clock is low
      if (!pins_s[0]) held <= ~pins_s[3];
    end
  end

  assign si_s       = pins_s[1];
  assign sel        = ~pins_s[2];
  assign cs_fall_ev = ~pins_s[2] & pins_q[2];
  assign cs_rise_ev = pins_s[2] & ~pins_q[2];
  assign sck_rise   = pins_s[0] & ~pins_q[0] & sel & ~held;
  assign sck_fall   = ~pins_s[0] & pins_q[0] & sel & ~held;

  // R9
  held_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held != $past(held)) |-> !$past(pins_s[0]));

endmodule

// File: rtl/spi_so_shift.sv
module spi_so_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              sel,
  input  logic              held,
  input  logic              stream_on,
  input  logic              use_status,
  input  logic [BYTE_W-1:0] mem_byte,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              so,
  output logic              so_oe,
  output logic              load_ev
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              active;

  assign load_ev = sck_fall & stream_on & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (!stream_on) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (sck_fall) begin
      if (cnt == '0) sreg <= use_status ? status_byte : mem_byte;
      else           sreg <= {sreg[BYTE_W-2:0], 1'b0};
      cnt    <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
      active <= 1'b1;
    end
  end

  assign so    = sreg[BYTE_W-1];
  assign so_oe = active & sel & ~held;

  // R2
  so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(sck_fall));

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              si_s,
  input  logic              cs_fall_ev,
  input  logic              cs_rise_ev,
  input  logic              load_ev,
  input  logic              wr_busy,
  output phase_t            phase,
  output logic [4:0]        bit_cnt,
  output logic [ADDR_W-1:0] addr_q,
  output logic              stream_on,
  output logic              use_status,
  output logic              wr_byte_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              sr_wr_req,
  output logic [BYTE_W-1:0] sr_wr_data
);
  localparam logic [XADDR_W-1:0] AMASK = XADDR_W'((1 << ADDR_W) - 1);
  localparam logic [4:0] OPC_LAST  = 5'(BYTE_W - 1);
  localparam logic [4:0] ADDR_LAST = 5'(XADDR_W - 1);

  logic [XADDR_W-1:0] sh;
  logic [BYTE_W-1:0]  byte_in;
  logic [XADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0]  addr_inc;
  latch_req_t         latch_pend;
  logic               sr_pend, data_seen, is_write;
  logic [BYTE_W-1:0]  sr_hold;

  assign byte_in  = {sh[BYTE_W-2:0], si_s};
  assign addr_in  = {sh[XADDR_W-2:0], si_s};
  assign addr_inc = ADDR_W'(addr_next(XADDR_W'(addr_q), AMASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bit_cnt <= '0; sh <= '0; addr_q <= '0;
      latch_pend <= PEND_NONE; sr_pend <= 1'b0; data_seen <= 1'b0;
      is_write <= 1'b0; sr_hold <= '0;
      wr_byte_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
      wel_set <= 1'b0; wel_clr <= 1'b0; sr_wr_req <= 1'b0; sr_wr_data <= '0;
    end else begin
      wr_byte_valid <= 1'b0; wr_commit <= 1'b0;
      wel_set <= 1'b0; wel_clr <= 1'b0; sr_wr_req <= 1'b0;
      if (cs_rise_ev) begin
        wel_set   <= (latch_pend == PEND_SET);
        wel_clr   <= (latch_pend == PEND_CLR);
        sr_wr_req <= sr_pend;
        if (sr_pend) sr_wr_data <= sr_hold;
        wr_commit <= data_seen;
        phase <= PH_IDLE; bit_cnt <= '0;
        latch_pend <= PEND_NONE; sr_pend <= 1'b0; data_seen <= 1'b0;
      end else if (cs_fall_ev) begin
        phase <= PH_OPC; bit_cnt <= '0;
        latch_pend <= PEND_NONE; sr_pend <= 1'b0; data_seen <= 1'b0;
      end else begin
        if (sck_rise) begin
          case (phase)
            PH_OPC: begin
              sh <= addr_in;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == OPC_LAST) begin
                bit_cnt <= '0;
                if (!op_known(byte_in) || (wr_busy && byte_in != OP_STAT_RD)) begin
                  phase <= PH_SKIP;
                end else begin
                  case (byte_in)
                    OP_WEN_SET: begin latch_pend <= PEND_SET; phase <= PH_SKIP; end
                    OP_WEN_CLR: begin latch_pend <= PEND_CLR; phase <= PH_SKIP; end
                    OP_STAT_RD: phase <= PH_STREAM_STAT;
                    OP_STAT_WR: begin is_write <= 1'b0; phase <= PH_DIN; end
                    OP_MEM_WR:  begin is_write <= 1'b1; phase <= PH_ADDR; end
                    default:    begin is_write <= 1'b0; phase <= PH_ADDR; end
                  endcase
                end
              end
            end
            PH_ADDR: begin
              sh <= addr_in;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == ADDR_LAST) begin
                bit_cnt <= '0;
                addr_q  <= addr_in[ADDR_W-1:0];
                phase   <= is_write ? PH_DIN : PH_STREAM_MEM;
              end
            end
            PH_DIN: begin
              sh <= addr_in;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == OPC_LAST) begin
                bit_cnt <= '0;
                if (is_write) begin
                  wr_byte_valid <= 1'b1;
                  wr_addr   <= addr_q;
                  wr_data   <= byte_in;
                  addr_q    <= addr_inc;
                  data_seen <= 1'b1;
                end else begin
                  sr_hold <= byte_in;
                  sr_pend <= 1'b1;
                  phase   <= PH_SKIP;
                end
              end
            end
            default: ;
          endcase
        end
        if (load_ev && phase == PH_STREAM_MEM) addr_q <= addr_inc;
      end
    end
  end

  assign stream_on  = (phase == PH_STREAM_MEM) || (phase == PH_STREAM_STAT);
  assign use_status = (phase == PH_STREAM_STAT);

  // R3
  cmd_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_set || wel_clr || sr_wr_req || wr_commit) |-> $past(cs_rise_ev));
  // R3
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set, wel_clr, sr_wr_req}));
  // R7
  byte_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_valid |-> $past(sck_rise));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPC && sck_rise && bit_cnt == OPC_LAST && wr_busy && !cs_rise_ev)
    |=> (phase == PH_SKIP || phase == PH_STREAM_STAT));

endmodule

// File: rtl/spi_mem_cmd_if.sv
module spi_mem_cmd_if
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic              wr_busy,
  input  logic [7:0]        status_in,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_byte_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              sr_wr_req,
  output logic [7:0]        sr_wr_data
);
  logic   sck_rise, sck_fall, si_s, sel, cs_fall_ev, cs_rise_ev, held;
  logic   stream_on, use_status, load_ev;
  phase_t phase;
  logic [4:0] bit_cnt;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .sel(sel),
    .cs_fall_ev(cs_fall_ev), .cs_rise_ev(cs_rise_ev), .held(held)
  );

  spi_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .si_s(si_s),
    .cs_fall_ev(cs_fall_ev), .cs_rise_ev(cs_rise_ev), .load_ev(load_ev),
    .wr_busy(wr_busy), .phase(phase), .bit_cnt(bit_cnt), .addr_q(rd_addr),
    .stream_on(stream_on), .use_status(use_status),
    .wr_byte_valid(wr_byte_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .wel_set(wel_set), .wel_clr(wel_clr),
    .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data)
  );

  spi_so_shift #(.BYTE_W(BYTE_W)) u_so (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .sel(sel), .held(held),
    .stream_on(stream_on), .use_status(use_status), .mem_byte(rd_data),
    .status_byte(status_in), .so(so), .so_oe(so_oe), .load_ev(load_ev)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !so_oe);
  // R10
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !so_oe);
  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_fall_ev && !cs_rise_ev) |=> $stable(bit_cnt));

endmodule

// File: tb/spi_mem_cmd_if_tb.sv
module spi_mem_cmd_if_tb;
  localparam int H = 8;   // clk cycles per serial half period
  localparam int DEPTH = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic so, so_oe, wr_busy = 1'b0;
  logic [7:0] status_in = 8'hA5;
  logic [10:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data, sr_wr_data;
  logic wr_byte_valid, wr_commit, wel_set, wel_clr, sr_wr_req;

  logic [7:0] mem [DEPTH];
  int n_chk = 0, n_fail = 0;
  int c_set = 0, c_clr = 0, c_sr = 0, c_commit = 0, c_byte = 0;
  logic [7:0] last_sr;
  logic [10:0] log_addr [8];
  logic [7:0]  log_data [8];
  bit cpol = 1'b0;

  always #10 clk = ~clk;

  spi_mem_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .wr_busy(wr_busy), .status_in(status_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_byte_valid(wr_byte_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr_req(sr_wr_req),
    .sr_wr_data(sr_wr_data)
  );

  assign rd_data = mem[rd_addr];

  always @(negedge clk) begin
    if (wel_set) c_set++;
    if (wel_clr) c_clr++;
    if (wr_commit) c_commit++;
    if (sr_wr_req) begin c_sr++; last_sr = sr_wr_data; end
    if (wr_byte_valid) begin
      if (c_byte < 8) begin log_addr[c_byte] = wr_addr; log_data[c_byte] = wr_data; end
      c_byte++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    c_set = 0; c_clr = 0; c_sr = 0; c_commit = 0; c_byte = 0;
  endtask

  task automatic sel_on();
    sck = cpol; wt(H);
    cs_n = 1'b0; wt(H);
  endtask

  task automatic sel_off();
    if (!cpol) sck = 1'b0;
    wt(H);
    cs_n = 1'b1; wt(2*H);
  endtask

  // shifts nb bits of tx MSB first; optional pause during bit hold_bit
  task automatic xfer(input logic [7:0] tx, input int nb, input int hold_bit,
                      output logic [7:0] rx, output int oe_cnt, output int held_oe);
    rx = '0; oe_cnt = 0; held_oe = 0;
    for (int b = 7; b >= 8 - nb; b--) begin
      sck = 1'b0; si = tx[b]; wt(H);
      if (hold_bit == b) begin
        hold_n = 1'b0; wt(H);
        for (int k = 0; k < 3; k++) begin
          si = ~si; sck = 1'b1; wt(H); if (so_oe) held_oe++;
          sck = 1'b0; wt(H); if (so_oe) held_oe++;
        end
        si = tx[b]; hold_n = 1'b1; wt(H);
      end
      rx[b] = so; if (so_oe) oe_cnt++;
      sck = 1'b1; wt(H);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; int o, h;
    xfer(tx, 8, -1, r, o, h);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [15:0] a);
    send(op); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic t_reset();
    chk(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
    chk(c_set + c_clr + c_sr + c_commit + c_byte == 0, "R1 reset pulses",
        c_set + c_clr + c_sr + c_commit + c_byte, 0);
  endtask

  task automatic t_latch();
    clr_counts();
    sel_on(); send(8'h06); wt(H);
    chk(c_set == 0, "R3 set before release", c_set, 0);
    sel_off();
    chk(c_set == 1 && c_clr == 0, "R3 set pulse", c_set, 1);
    sel_on(); send(8'h04); sel_off();
    chk(c_clr == 1 && c_set == 1, "R3 clear pulse", c_clr, 1);
  endtask

  task automatic t_abort();
    logic [7:0] r; int o, h;
    clr_counts();
    sel_on(); xfer(8'h06, 5, -1, r, o, h); sel_off();
    chk(c_set == 0, "R12 partial opcode dropped", c_set, 0);
    sel_on(); send_hdr(8'h03, 16'h0021); xfer(8'h00, 8, -1, r, o, h); sel_off();
    chk(r == mem[11'h021], "R12 clean restart", r, mem[11'h021]);
  endtask

  task automatic t_read(input logic [15:0] a, input int nbytes, input string tag);
    logic [7:0] r; int o, h;
    int ea;
    ea = a % DEPTH;
    sel_on(); send_hdr(8'h03, a);
    for (int i = 0; i < nbytes; i++) begin
      xfer(8'h00, 8, -1, r, o, h);
      chk(r == mem[ea] && o == 8, tag, r, mem[ea]);
      ea = (ea + 1) % DEPTH;
    end
    sel_off();
    chk(so_oe == 1'b0, "R1 oe off after release", so_oe, 0);
  endtask

  task automatic t_status();
    logic [7:0] r; int o, h;
    wr_busy = 1'b1; status_in = 8'h5A;
    sel_on(); send(8'h05);
    for (int i = 0; i < 2; i++) begin
      xfer(8'h00, 8, -1, r, o, h);
      chk(r == 8'h5A && o == 8, "R6 status stream", r, 8'h5A);
    end
    sel_off();
    wr_busy = 1'b0;
  endtask

  task automatic t_busy();
    logic [7:0] r; int o, h;
    clr_counts(); wr_busy = 1'b1;
    sel_on(); send_hdr(8'h03, 16'h0010); xfer(8'h00, 8, -1, r, o, h); sel_off();
    chk(o == 0, "R11 read ignored", o, 0);
    sel_on(); send(8'h06); sel_off();
    sel_on(); send_hdr(8'h02, 16'h0010); send(8'h99); sel_off();
    chk(c_set + c_byte + c_commit == 0, "R11 no pulses", c_set + c_byte + c_commit, 0);
    wr_busy = 1'b0;
  endtask

  task automatic t_invalid();
    logic [7:0] r; int o, h, tot;
    clr_counts(); tot = 0;
    sel_on(); send(8'h55); send(8'h03); send(8'h00); send(8'h10);
    xfer(8'h02, 8, -1, r, o, h); tot += o;
    xfer(8'h06, 8, -1, r, o, h); tot += o;
    sel_off();
    chk(tot == 0, "R10 output muted", tot, 0);
    chk(c_set + c_byte + c_commit + c_sr == 0, "R10 no pulses",
        c_set + c_byte + c_commit + c_sr, 0);
    t_read(16'h0010, 1, "R10 recovers on next select");
  endtask

  task automatic t_write();
    logic [7:0] r; int o, h;
    clr_counts();
    sel_on(); send_hdr(8'h02, 16'h8123); send(8'h11); send(8'h22);
    xfer(8'hFF, 4, -1, r, o, h); wt(H);
    chk(c_commit == 0, "R7 no commit before release", c_commit, 0);
    sel_off();
    chk(c_byte == 2, "R7 byte count", c_byte, 2);
    chk(log_addr[0] == 11'h123 && log_data[0] == 8'h11, "R7 first byte", log_addr[0], 11'h123);
    chk(log_addr[1] == 11'h124 && log_data[1] == 8'h22, "R7 second byte", log_addr[1], 11'h124);
    chk(c_commit == 1, "R7 commit", c_commit, 1);
    clr_counts();
    sel_on(); send(8'h01); send(8'h8C); send(8'h77); sel_off();
    chk(c_sr == 1 && last_sr == 8'h8C, "R8 status write", last_sr, 8'h8C);
    chk(c_byte == 0 && c_commit == 0, "R8 no array write", c_byte, 0);
  endtask

  task automatic t_hold();
    logic [7:0] r; int o, h;
    clr_counts();
    sel_on();
    xfer(8'h03, 8, 4, r, o, h);
    xfer(8'h00, 8, 2, r, o, h);
    xfer(8'h40, 8, -1, r, o, h);
    xfer(8'h00, 8, 5, r, o, h);
    chk(r == mem[11'h040], "R9 data intact after pause", r, mem[11'h040]);
    chk(h == 0, "R9 oe off while paused", h, 0);
    chk(o == 8, "R9 oe back after release", o, 8);
    sel_off();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
    wt(4); rst_n = 1'b1; wt(4);
    t_reset();
    t_latch();
    t_abort();
    t_read(16'h0010, 3, "R4 sequential read mode0");
    t_read(16'hF7FF, 2, "R5 wrap and upper bits ignored");
    cpol = 1'b1;
    t_read(16'h0123, 2, "R2 read mode3");
    t_status();
    cpol = 1'b0;
    t_busy();
    t_invalid();
    t_write();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule